// File: doc/BRIEF.md
# Renaming Register File with Forwarding

This block is the register file of an out-of-order integer core. It holds 32 registers of 32 bits. Next to each register it keeps a busy flag and the rename tag of the instruction that will produce the register's next value. At decode the block reads two source registers at once. For each source it returns three things: the value, the rename tag, and a ready flag that says whether the value is already usable. In the same cycle it can rename one destination register. It takes the lowest-numbered free tag from a pool of 32, shows that tag on `destTag`, and marks the register busy under that tag.

When an execution unit finishes, it presents a tag and a result. The tag goes back to the pool. The register that still carries that tag takes the result and becomes ready. A register that has since been renamed under a newer tag is left untouched. A bypass makes a result that is written back in a cycle visible to that same cycle's source reads. If the pool is empty when a destination needs a tag, the block raises a stall and leaves the register as it was.

Top module: `rename_regfile`

## Requirements
- R1: After reset every register reads value 0 with tag 0 and ready 1. All 32 tags are free, so `destTag` shows 0 and `renameStall` is 0.
- R2: With no writeback pending, a source read returns the register's stored value and current tag. Its ready flag is 1 exactly when the register is not busy.
- R3: When `decValid` is 1, `decDest` is non-zero and a tag is free, `destTag` shows the lowest-numbered free tag. From the next cycle that register reads ready 0 with that tag, and the tag is no longer free.
- R4: When `wbValid` is 1 and a busy register's current tag equals `wbTag`, that register holds `wbData` and reads ready 1 from the next cycle.
- R5: A writeback returns `wbTag` to the pool from the next cycle on. The returned tag is then chosen again if it is the lowest free one.
- R6: In a cycle with `wbValid` 1, a source whose register is busy under a tag equal to `wbTag` reads `wbData` with ready 1 in that same cycle.
- R7: Register 0 always reads value 0, tag 0 and ready 1. A rename with `decDest` 0 allocates no tag and never stalls.
- R8: When a rename needs a tag and none is free, `renameStall` is 1 in that cycle. The destination keeps its previous tag and busy state.
- R9: A writeback whose tag is no longer the current tag of any busy register changes no register value. The tag is still freed.
- R10: A source read in the same cycle as a rename of that register returns the state from before the rename.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| srcA | input | 5 | Index of the first source register |
| srcB | input | 5 | Index of the second source register |
| decValid | input | 1 | A decoded instruction asks to rename `decDest` |
| decDest | input | 5 | Destination register index |
| wbValid | input | 1 | A result is being written back |
| wbTag | input | 5 | Rename tag of the result |
| wbData | input | 32 | Result value |
| srcAValue | output | 32 | Value of the first source |
| srcATag | output | 5 | Rename tag of the first source |
| srcAReady | output | 1 | First source value is usable |
| srcBValue | output | 32 | Value of the second source |
| srcBTag | output | 5 | Rename tag of the second source |
| srcBReady | output | 1 | Second source value is usable |
| destTag | output | 5 | Tag given to the destination this cycle (lowest free tag) |
| renameStall | output | 1 | No free tag for the requested rename |

## Verification
The bench targets the stale writeback. There, a register was renamed twice and the older producer finishes first. A design that matched by register index, or that did not compare the current tag, would overwrite the register with an outdated result and mark it ready. It also checks the same-cycle bypass: without it, a source would read as waiting for a value that is already on the writeback bus. Two ordering cases are covered as well. A rename and a read of the same register in one cycle must show the old state. A rename must stall cleanly once all 32 tags are in use. A design that wrapped the tag pool would hand out a tag that is still in flight.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  localparam int NumRegs = 32;
  localparam int DataW   = 32;
  localparam int TagW    = 5;
  localparam int IdxW    = $clog2(NumRegs);
  localparam int NumTags = 1 << TagW;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic            renameEn;
    logic [IdxW-1:0] renameReg;
    logic [TagW-1:0] renameTag;
  } rrf_strobe_t;
endpackage

// File: rtl/rrf_ctrl.sv
module rrf_ctrl
  import rrf_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            decValid,
  input  logic [IdxW-1:0] decDest,
  input  logic            wbValid,
  input  logic [TagW-1:0] wbTag,
  output rrf_strobe_t     strobe,
  output logic [TagW-1:0] nextTag,
  output logic            stall
);
  logic [NumTags-1:0] freeMask;
  logic               haveFree;
  logic               wantTag;

  // Lowest-numbered free tag
  always_comb begin
    haveFree = 1'b0;
    nextTag  = '0;
    for (int t = NumTags - 1; t >= 0; t--) begin
      if (freeMask[t]) begin
        haveFree = 1'b1;
        nextTag  = TagW'(t);
      end
    end
  end

  assign wantTag = decValid && (decDest != '0);
  assign stall   = wantTag && !haveFree;

  always_comb begin
    strobe.renameEn  = wantTag && haveFree;
    strobe.renameReg = decDest;
    strobe.renameTag = nextTag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freeMask <= '1;
    end else begin
      if (wbValid) freeMask[wbTag] <= 1'b1;
      if (strobe.renameEn) freeMask[nextTag] <= 1'b0;
    end
  end
endmodule

// File: rtl/rrf_datapath.sv
module rrf_datapath
  import rrf_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  rrf_strobe_t      strobe,
  input  logic             wbValid,
  input  logic [TagW-1:0]  wbTag,
  input  logic [DataW-1:0] wbData,
  input  logic [IdxW-1:0]  srcIdx   [2],
  output logic [DataW-1:0] srcValue [2],
  output logic [TagW-1:0]  srcTag   [2],
  output logic             srcReady [2]
);
  logic [DataW-1:0] regVal  [NumRegs];
  logic [TagW-1:0]  regTag  [NumRegs];
  logic             regBusy [NumRegs];

  // Entry 0 stays constant
  assign regVal[0]  = '0;
  assign regTag[0]  = '0;
  assign regBusy[0] = 1'b0;

  for (genvar i = 1; i < NumRegs; i++) begin : g_entry
    logic wbHit;
    assign wbHit = wbValid && regBusy[i] && (regTag[i] == wbTag);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        regVal[i]  <= '0;
        regTag[i]  <= '0;
        regBusy[i] <= 1'b0;
      end else begin
        if (wbHit) begin
          regVal[i]  <= wbData;
          regBusy[i] <= 1'b0;
        end
        // A rename in the same cycle wins over the release
        if (strobe.renameEn && (strobe.renameReg == IdxW'(i))) begin
          regBusy[i] <= 1'b1;
          regTag[i]  <= strobe.renameTag;
        end
      end
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic fwdHit;
    assign fwdHit = wbValid && regBusy[srcIdx[p]] && (regTag[srcIdx[p]] == wbTag);
    always_comb begin
      srcTag[p]   = regTag[srcIdx[p]];
      srcValue[p] = fwdHit ? wbData : regVal[srcIdx[p]];
      srcReady[p] = fwdHit || !regBusy[srcIdx[p]];
    end
  end
endmodule

// File: rtl/rename_regfile.sv
module rename_regfile
  import rrf_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [IdxW-1:0]  srcA,
  input  logic [IdxW-1:0]  srcB,
  input  logic             decValid,
  input  logic [IdxW-1:0]  decDest,
  input  logic             wbValid,
  input  logic [TagW-1:0]  wbTag,
  input  logic [DataW-1:0] wbData,
  output logic [DataW-1:0] srcAValue,
  output logic [TagW-1:0]  srcATag,
  output logic             srcAReady,
  output logic [DataW-1:0] srcBValue,
  output logic [TagW-1:0]  srcBTag,
  output logic             srcBReady,
  output logic [TagW-1:0]  destTag,
  output logic             renameStall
);
  rrf_strobe_t      strobe;
  logic [IdxW-1:0]  srcIdx   [2];
  logic [DataW-1:0] srcValue [2];
  logic [TagW-1:0]  srcTag   [2];
  logic             srcReady [2];

  assign srcIdx[0] = srcA;
  assign srcIdx[1] = srcB;

  rrf_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .decValid (decValid),
    .decDest  (decDest),
    .wbValid  (wbValid),
    .wbTag    (wbTag),
    .strobe   (strobe),
    .nextTag  (destTag),
    .stall    (renameStall)
  );

  rrf_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wbValid  (wbValid),
    .wbTag    (wbTag),
    .wbData   (wbData),
    .srcIdx   (srcIdx),
    .srcValue (srcValue),
    .srcTag   (srcTag),
    .srcReady (srcReady)
  );

  assign srcAValue = srcValue[0];
  assign srcATag   = srcTag[0];
  assign srcAReady = srcReady[0];
  assign srcBValue = srcValue[1];
  assign srcBTag   = srcTag[1];
  assign srcBReady = srcReady[1];
endmodule

// File: rtl/rrf_checker.sv
module rrf_checker
  import rrf_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [IdxW-1:0]  srcA,
  input logic             decValid,
  input logic [IdxW-1:0]  decDest,
  input logic             wbValid,
  input logic [TagW-1:0]  wbTag,
  input logic [DataW-1:0] wbData,
  input logic [DataW-1:0] srcAValue,
  input logic [TagW-1:0]  srcATag,
  input logic             srcAReady,
  input logic [TagW-1:0]  destTag,
  input logic             renameStall
);
  p_zero_reg_r7: assert property (@(posedge clk) disable iff (!rstN)
    (srcA == '0) |-> (srcAValue == '0 && srcAReady && srcATag == '0));

  p_stall_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    renameStall |-> (decValid && decDest != '0));

  p_bypass_ready_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && srcA != '0 && srcATag == wbTag) |-> srcAReady);

  p_renamed_waits_r3: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && decDest != '0 && !renameStall) |=>
      (!(srcA == $past(decDest) && !(wbValid && wbTag == $past(destTag)))
       || (!srcAReady && srcATag == $past(destTag))));

  p_ready_value_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && srcA != '0 && srcATag == wbTag && $past(srcATag) == wbTag
     && !$past(srcAReady) && $stable(srcA)) |-> (srcAValue == wbData));
endmodule

bind rename_regfile rrf_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .srcA        (srcA),
  .decValid    (decValid),
  .decDest     (decDest),
  .wbValid     (wbValid),
  .wbTag       (wbTag),
  .wbData      (wbData),
  .srcAValue   (srcAValue),
  .srcATag     (srcATag),
  .srcAReady   (srcAReady),
  .destTag     (destTag),
  .renameStall (renameStall)
);

// File: tb/rename_regfile_tb.sv
module rename_regfile_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic [4:0]  srcA, srcB, decDest, wbTag;
  logic        decValid, wbValid;
  logic [31:0] wbData;
  logic [31:0] srcAValue, srcBValue;
  logic [4:0]  srcATag, srcBTag, destTag;
  logic        srcAReady, srcBReady, renameStall;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  rename_regfile u_dut (
    .clk(clk), .rstN(rstN), .srcA(srcA), .srcB(srcB),
    .decValid(decValid), .decDest(decDest),
    .wbValid(wbValid), .wbTag(wbTag), .wbData(wbData),
    .srcAValue(srcAValue), .srcATag(srcATag), .srcAReady(srcAReady),
    .srcBValue(srcBValue), .srcBTag(srcBTag), .srcBReady(srcBReady),
    .destTag(destTag), .renameStall(renameStall)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        dv;
    logic [4:0]  dd;
    logic        wv;
    logic [4:0]  wt;
    logic [31:0] wd;
    logic [4:0]  sa;
    logic [31:0] eVal;
    logic        eRdy;
    logic [4:0]  eTag;
    logic [4:0]  eDest;
  } vec_t;

  // Rows: req, dv, dd, wv, wt, wd, srcA, expected value/ready/tag, destTag
  localparam vec_t Table [10] = '{
    '{4'd3,  1'b1, 5'd5, 1'b0, 5'd0, 32'h0,  5'd5, 32'h0,  1'b1, 5'd0, 5'd0}, // R3 rename x5 (read sees old, R10)
    '{4'd3,  1'b1, 5'd6, 1'b0, 5'd0, 32'h0,  5'd5, 32'h0,  1'b0, 5'd0, 5'd1}, // R3 x5 waits, x6 gets tag 1
    '{4'd6,  1'b0, 5'd0, 1'b1, 5'd0, 32'h11, 5'd5, 32'h11, 1'b1, 5'd0, 5'd2}, // R6 bypass of tag 0
    '{4'd5,  1'b1, 5'd7, 1'b0, 5'd0, 32'h0,  5'd5, 32'h11, 1'b1, 5'd0, 5'd0}, // R4 R5 tag 0 reused
    '{4'd2,  1'b0, 5'd0, 1'b0, 5'd0, 32'h0,  5'd6, 32'h0,  1'b0, 5'd1, 5'd2}, // R2 busy read
    '{4'd10, 1'b1, 5'd6, 1'b0, 5'd0, 32'h0,  5'd6, 32'h0,  1'b0, 5'd1, 5'd2}, // R10 rename x6 again
    '{4'd9,  1'b0, 5'd0, 1'b1, 5'd1, 32'h33, 5'd6, 32'h0,  1'b0, 5'd2, 5'd3}, // R9 stale writeback
    '{4'd9,  1'b0, 5'd0, 1'b0, 5'd0, 32'h0,  5'd6, 32'h0,  1'b0, 5'd2, 5'd1}, // R9 R5 x6 kept, tag 1 free
    '{4'd6,  1'b0, 5'd0, 1'b1, 5'd2, 32'h44, 5'd6, 32'h44, 1'b1, 5'd2, 5'd1}, // R6 bypass current tag
    '{4'd4,  1'b0, 5'd0, 1'b0, 5'd0, 32'h0,  5'd6, 32'h44, 1'b1, 5'd2, 5'd1}  // R4 value held
  };

  task automatic drive(input logic dv, input logic [4:0] dd, input logic wv,
                       input logic [4:0] wt, input logic [31:0] wd,
                       input logic [4:0] sa, input logic [4:0] sb);
    @(negedge clk);
    decValid = dv; decDest = dd; wbValid = wv; wbTag = wt; wbData = wd;
    srcA = sa; srcB = sb;
    #2;
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    drive(1'b0, 5'd0, 1'b0, 5'd0, 32'h0, 5'd0, 5'd0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    doReset();
    // R1 reset state
    drive(1'b0, 5'd0, 1'b0, 5'd0, 32'h0, 5'd9, 5'd31);
    check("R1 srcA", {srcAValue, 26'd0, srcATag, srcAReady}, {32'h0, 26'd0, 5'd0, 1'b1});
    check("R1 srcB", {srcBValue, 26'd0, srcBTag, srcBReady}, {32'h0, 26'd0, 5'd0, 1'b1});
    check("R1 pool", {58'd0, destTag, renameStall}, {58'd0, 5'd0, 1'b0});

    for (int i = 0; i < 10; i++) begin
      drive(Table[i].dv, Table[i].dd, Table[i].wv, Table[i].wt, Table[i].wd, Table[i].sa, 5'd0);
      nChecks++;
      if ({srcAValue, srcAReady, srcATag, destTag, renameStall} !==
          {Table[i].eVal, Table[i].eRdy, Table[i].eTag, Table[i].eDest, 1'b0}) begin
        nFails++;
        $display("FAIL row %0d R%0d actual=%h/%b/%0d/%0d/%b expected=%h/%b/%0d/%0d/0",
                 i, Table[i].req, srcAValue, srcAReady, srcATag, destTag, renameStall,
                 Table[i].eVal, Table[i].eRdy, Table[i].eTag, Table[i].eDest);
      end
    end

    // R2 both ports at once: x5 ready 0x11, x7 busy tag 0
    drive(1'b0, 5'd0, 1'b0, 5'd0, 32'h0, 5'd5, 5'd7);
    check("R2 portB busy", {srcBValue, 26'd0, srcBTag, srcBReady}, {32'h0, 26'd0, 5'd0, 1'b0});
    check("R2 portA", {srcAValue, 31'd0, srcAReady}, {32'h11, 31'd0, 1'b1});

    // R1 reset clears earlier state
    doReset();
    drive(1'b0, 5'd0, 1'b0, 5'd0, 32'h0, 5'd6, 5'd5);
    check("R1 after reset", {srcAValue, 26'd0, srcATag, srcAReady}, {32'h0, 26'd0, 5'd0, 1'b1});

    // R8 drain the pool by renaming x1 32 times
    for (int k = 0; k < 32; k++) begin
      drive(1'b1, 5'd1, 1'b0, 5'd0, 32'h0, 5'd0, 5'd0);
      if (k == 31) check("R3 last tag", {59'd0, destTag}, {59'd0, 5'd31});
    end
    drive(1'b1, 5'd1, 1'b0, 5'd0, 32'h0, 5'd1, 5'd0);
    check("R8 stall", {63'd0, renameStall}, {63'd0, 1'b1});
    // R7 rename of x0 never stalls
    drive(1'b1, 5'd0, 1'b0, 5'd0, 32'h0, 5'd0, 5'd0);
    check("R7 x0 no stall", {63'd0, renameStall}, {63'd0, 1'b0});
    check("R7 x0 read", {srcAValue, 26'd0, srcATag, srcAReady}, {32'h0, 26'd0, 5'd0, 1'b1});
    drive(1'b0, 5'd0, 1'b0, 5'd0, 32'h0, 5'd1, 5'd0);
    check("R8 x1 unchanged", {58'd0, srcATag, srcAReady}, {58'd0, 5'd31, 1'b0});
    // R9 stale tag 5 frees a tag but leaves x1
    drive(1'b0, 5'd0, 1'b1, 5'd5, 32'h55, 5'd1, 5'd0);
    check("R9 stale no bypass", {srcAValue, 31'd0, srcAReady}, {32'h0, 31'd0, 1'b0});
    drive(1'b0, 5'd0, 1'b0, 5'd0, 32'h0, 5'd1, 5'd0);
    check("R5 freed tag offered", {58'd0, destTag, renameStall}, {58'd0, 5'd5, 1'b0});
    check("R9 x1 intact", {srcAValue, 31'd0, srcAReady}, {32'h0, 31'd0, 1'b0});
    // R4 current tag lands
    drive(1'b0, 5'd0, 1'b1, 5'd31, 32'hABCD, 5'd1, 5'd0);
    check("R6 bypass", {srcAValue, 31'd0, srcAReady}, {32'hABCD, 31'd0, 1'b1});
    drive(1'b0, 5'd0, 1'b0, 5'd0, 32'h0, 5'd1, 5'd0);
    check("R4 stored", {srcAValue, 26'd0, srcATag, srcAReady}, {32'hABCD, 26'd0, 5'd31, 1'b1});

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule